// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block keeps the control state for four 256-position digital potentiometers. Each channel has a volatile 8-bit wiper code, which drives the tap selection of the resistor array, and four 8-bit stored settings. The stored settings model non-volatile cells: they keep their contents across reset, and each write to them keeps the block busy for a set number of cycles. A parallel command port gives read and write access to both tiers. It also copies a setting between a wiper and its own channel's store, and it steps a wiper up or down by one tap.

When reset is released, the block copies stored setting 0 of each channel into that channel's wiper. It does this one channel per cycle and accepts no command until all four are done. An active-low write-protect input blocks every command that would change a stored setting. Wiper changes stay allowed while it is low. The board is expected to pull the input high when it is left open, so an open input lets every command through. The serial bus front end and the analog array are outside this block. The only outputs toward the array are the packed wiper codes.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: While rst_n is low, wiper_out is all zero, ready is low, err is low and rsp_rdata is zero.
- R2: After rst_n rises, the wipers are loaded from stored setting 0 at the next four clock edges, one channel per edge in order 0, 1, 2, 3. A channel not yet loaded shows code 0. ready is high only after the fourth edge.
- R3: Stored settings keep their contents through rst_n. Before any write, setting idx of channel ch holds ch*64 + idx*16 + 10.
- R4: A command is taken at a clock edge where cmd_valid and ready are both high. The opcode values are: 0 read wiper, 1 write wiper, 2 read setting, 3 write setting, 4 copy wiper to setting, 5 copy setting to wiper, 6 step up, 7 step down.
- R5: A wiper write takes effect at the accepting edge, and ready is then low for exactly one cycle.
- R6: A read (opcode 0 or 2) puts the selected wiper or setting on rsp_rdata at the accepting edge. ready is low for one cycle. rsp_rdata holds its value until the next read.
- R7: A setting write stores cmd_wdata at the accepting edge, and ready is then low for NV_BUSY cycles.
- R8: Copying a wiper to a setting stores that channel's current wiper code into the selected setting of the same channel, with the same NV_BUSY hold.
- R9: Copying a setting to a wiper loads the selected setting of the channel into its wiper, and ready is low for one cycle.
- R10: A step changes the wiper by one tap. A step up at 255 and a step down at 0 leave the code unchanged.
- R11: While wp_n is low, opcodes 3 and 4 are refused. A refused command changes no register, raises err for exactly one cycle after the accepting edge and holds ready low for one cycle. Wiper writes still take effect.
- R12: A command kept valid while ready is low is taken exactly once, at the first edge where ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the recall |
| wp_n | input | 1 | Active-low write protect for stored settings |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode (see R4) |
| cmd_ch | input | 2 | Channel select |
| cmd_reg | input | 2 | Stored setting select |
| cmd_wdata | input | 8 | Write data |
| ready | output | 1 | Block can accept a command |
| rsp_rdata | output | 8 | Read result |
| err | output | 1 | One-cycle pulse on a refused command |
| wiper_out | output | 32 | Wiper codes, channel n in bits 8n+7:8n |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the end of a stored-setting busy period and a new command that has been waiting. The bench keeps a step command valid through the whole busy window and checks that the wiper moved by exactly one tap once ready returned. The second pair is write protect and a command that writes a setting. The bench drives wp_n low at random around such commands and judges each outcome against a model that updates its own copy of the registers only when the command is allowed.

// File: rtl/wpot_pkg.sv
package wpot_pkg;

  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DATA  = 3'd2,
    OP_WR_DATA  = 3'd3,
    OP_SAVE     = 3'd4,
    OP_LOAD     = 3'd5,
    OP_INC      = 3'd6,
    OP_DEC      = 3'd7
  } wpot_op_e;

  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_HOLD   = 2'd2
  } wpot_state_e;

  typedef enum logic [1:0] {
    STEP_SET  = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } wpot_step_e;

  // Commands that change a stored setting.
  function automatic logic op_writes_store(input wpot_op_e op);
    return (op == OP_WR_DATA) || (op == OP_SAVE);
  endfunction

endpackage

// File: rtl/wpot_ctrl_fsm.sv
module wpot_ctrl_fsm
  import wpot_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int NV_BUSY = 12,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CNT_W  = $clog2(NV_BUSY + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  wpot_op_e        cmd_op,
  input  logic            wp_n,
  output logic            ready,
  output logic            accept,
  output logic            refuse,
  output logic            nv_we,
  output logic            recall_en,
  output logic [CH_W-1:0] recall_idx,
  output logic            err
);

  wpot_state_e      state;
  logic [CNT_W-1:0] hold_cnt;
  logic             store_op;

  assign ready     = (state == ST_IDLE);
  assign recall_en = (state == ST_RECALL);
  assign accept    = ready && cmd_valid;
  assign store_op  = op_writes_store(cmd_op);
  assign refuse    = accept && store_op && !wp_n;
  assign nv_we     = accept && store_op && wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RECALL;
      recall_idx <= '0;
      hold_cnt   <= '0;
      err        <= 1'b0;
    end else begin
      err <= refuse;
      unique case (state)
        ST_RECALL: begin
          if (recall_idx == CH_W'(NCH - 1)) state <= ST_IDLE;
          recall_idx <= recall_idx + 1'b1;
        end
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_HOLD;
            hold_cnt <= nv_we ? CNT_W'(NV_BUSY) : CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (hold_cnt == CNT_W'(1)) state <= ST_IDLE;
          hold_cnt <= hold_cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wpot_wiper_bank.sv
module wpot_wiper_bank
  import wpot_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] load_en,
  input  wpot_step_e     mode,
  input  logic [W-1:0]   load_val,
  output logic [W-1:0]   code [NCH]
);

  localparam logic [W-1:0] CODE_MAX = '1;

  // Saturating step or direct load.
  function automatic logic [W-1:0] next_code(input logic [W-1:0] cur,
                                             input wpot_step_e m,
                                             input logic [W-1:0] val);
    case (m)
      STEP_UP:   return (cur == CODE_MAX) ? cur : cur + 1'b1;
      STEP_DOWN: return (cur == '0) ? cur : cur - 1'b1;
      default:   return val;
    endcase
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          code[c] <= '0;
      else if (load_en[c]) code[c] <= next_code(code[c], mode, load_val);
    end
  end

endmodule

// File: rtl/wpot_nv_array.sv
module wpot_nv_array #(
  parameter int NCH    = 4,
  parameter int NREG   = 4,
  parameter int W      = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RG_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            we,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [RG_W-1:0] wr_rg,
  input  logic [W-1:0]    wr_data,
  input  logic [CH_W-1:0] rd_ch,
  input  logic [RG_W-1:0] rd_rg,
  output logic [W-1:0]    rd_data
);

  logic [W-1:0] cells [NCH][NREG];

  // Factory contents of a never-written cell.
  function automatic logic [W-1:0] factory_value(input int ch, input int idx);
    return W'(ch * 64 + idx * 16 + 10);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NREG; r++)
        cells[c][r] = factory_value(c, r);
  end

  // No reset: the contents survive rst_n.
  always_ff @(posedge clk) begin
    if (we) cells[wr_ch][wr_rg] <= wr_data;
  end

  assign rd_data = cells[rd_ch][rd_rg];

endmodule

// File: rtl/quad_wiper_ctrl.sv
module quad_wiper_ctrl
  import wpot_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int NREG    = 4,
  parameter int WIPER_W = 8,
  parameter int NV_BUSY = 12,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RG_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [CH_W-1:0]        cmd_ch,
  input  logic [RG_W-1:0]        cmd_reg,
  input  logic [WIPER_W-1:0]     cmd_wdata,
  output logic                   ready,
  output logic [WIPER_W-1:0]     rsp_rdata,
  output logic                   err,
  output logic [NCH*WIPER_W-1:0] wiper_out
);

  wpot_op_e           op;
  logic               accept, refuse, nv_we, recall_en;
  logic [CH_W-1:0]    recall_idx;
  logic [WIPER_W-1:0] code [NCH];
  logic [WIPER_W-1:0] cur_wiper;
  logic [NCH-1:0]     load_en;
  wpot_step_e         mode;
  logic [WIPER_W-1:0] load_val;
  logic [CH_W-1:0]    nv_rd_ch;
  logic [RG_W-1:0]    nv_rd_rg;
  logic [WIPER_W-1:0] nv_rd_data;
  logic [WIPER_W-1:0] nv_wr_data;
  logic               acc_inc, acc_dec;

  assign op        = wpot_op_e'(cmd_op);
  assign cur_wiper = code[cmd_ch];
  assign acc_inc   = accept && (op == OP_INC);
  assign acc_dec   = accept && (op == OP_DEC);

  wpot_ctrl_fsm #(.NCH(NCH), .NV_BUSY(NV_BUSY)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (op),
    .wp_n      (wp_n),
    .ready     (ready),
    .accept    (accept),
    .refuse    (refuse),
    .nv_we     (nv_we),
    .recall_en (recall_en),
    .recall_idx(recall_idx),
    .err       (err)
  );

  // The recall and the commands never overlap, so they share one read port.
  assign nv_rd_ch   = recall_en ? recall_idx : cmd_ch;
  assign nv_rd_rg   = recall_en ? '0 : cmd_reg;
  assign nv_wr_data = (op == OP_WR_DATA) ? cmd_wdata : cur_wiper;

  wpot_nv_array #(.NCH(NCH), .NREG(NREG), .W(WIPER_W)) u_nv (
    .clk    (clk),
    .we     (nv_we),
    .wr_ch  (cmd_ch),
    .wr_rg  (cmd_reg),
    .wr_data(nv_wr_data),
    .rd_ch  (nv_rd_ch),
    .rd_rg  (nv_rd_rg),
    .rd_data(nv_rd_data)
  );

  always_comb begin
    load_en  = '0;
    mode     = STEP_SET;
    load_val = nv_rd_data;
    if (recall_en) begin
      load_en[recall_idx] = 1'b1;
    end else if (accept) begin
      unique case (op)
        OP_WR_WIPER: begin
          load_en[cmd_ch] = 1'b1;
          load_val        = cmd_wdata;
        end
        OP_LOAD: load_en[cmd_ch] = 1'b1;
        OP_INC: begin
          load_en[cmd_ch] = 1'b1;
          mode            = STEP_UP;
        end
        OP_DEC: begin
          load_en[cmd_ch] = 1'b1;
          mode            = STEP_DOWN;
        end
        default: ;
      endcase
    end
  end

  wpot_wiper_bank #(.NCH(NCH), .W(WIPER_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .mode    (mode),
    .load_val(load_val),
    .code    (code)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign wiper_out[c*WIPER_W +: WIPER_W] = code[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (accept) begin
      if (op == OP_RD_WIPER)     rsp_rdata <= cur_wiper;
      else if (op == OP_RD_DATA) rsp_rdata <= nv_rd_data;
    end
  end

endmodule

// File: rtl/wpot_chk.sv
module wpot_chk #(
  parameter int NCH = 4,
  parameter int W   = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           err,
  input logic           refuse,
  input logic           nv_we,
  input logic           acc_inc,
  input logic           acc_dec,
  input logic [W-1:0]   cur_wiper,
  input logic [NCH*W-1:0] wiper_out
);

  // R11
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> err);

  // R11
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> $stable(wiper_out));

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R10
  inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_inc && (cur_wiper == {W{1'b1}})) |=> $stable(wiper_out));

  // R10
  dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dec && (cur_wiper == '0)) |=> $stable(wiper_out));

  // R10
  inc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_inc && (cur_wiper != {W{1'b1}})) |=> !$stable(wiper_out));

  // R7
  nv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> !ready);

endmodule

bind quad_wiper_ctrl wpot_chk #(.NCH(NCH), .W(WIPER_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .err      (err),
  .refuse   (refuse),
  .nv_we    (nv_we),
  .acc_inc  (acc_inc),
  .acc_dec  (acc_dec),
  .cur_wiper(cur_wiper),
  .wiper_out(wiper_out)
);

// File: tb/quad_wiper_ctrl_test.sv
module quad_wiper_ctrl_test;

  localparam int BUSY = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_ch = '0;
  logic [1:0]  cmd_reg = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        ready;
  logic [7:0]  rsp_rdata;
  logic        err;
  logic [31:0] wiper_out;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_w [4];
  int exp_nv [16];
  int exp_rd = 0;

  always #2 clk = ~clk;

  quad_wiper_ctrl #(.NV_BUSY(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .ready(ready), .rsp_rdata(rsp_rdata), .err(err), .wiper_out(wiper_out)
  );

  function automatic int factory(input int ch, input int idx);
    return 64 * ch + 16 * idx + 10;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 2: return "R6";
      1:    return "R5";
      3:    return "R7";
      4:    return "R8";
      5:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_wipers(input string tag);
    for (int c = 0; c < 4; c++) check(tag, int'(wiper_out[c*8 +: 8]), exp_w[c]);
  endtask

  // Bench model of one command; returns the expected ready-low length, err, rdata.
  task automatic model(input int op, input int ch, input int rg, input int dat,
                       input int wp, output int elow, output int eerr, output int erd);
    elow = 1; eerr = 0;
    case (op)
      0: exp_rd = exp_w[ch];
      1: exp_w[ch] = dat;
      2: exp_rd = exp_nv[ch*4 + rg];
      3: if (wp != 0) begin exp_nv[ch*4 + rg] = dat; elow = BUSY; end else eerr = 1;
      4: if (wp != 0) begin exp_nv[ch*4 + rg] = exp_w[ch]; elow = BUSY; end else eerr = 1;
      5: exp_w[ch] = exp_nv[ch*4 + rg];
      6: if (exp_w[ch] < 255) exp_w[ch] = exp_w[ch] + 1;
      default: if (exp_w[ch] > 0) exp_w[ch] = exp_w[ch] - 1;
    endcase
    erd = exp_rd;
  endtask

  task automatic issue(input int op, input int ch, input int rg, input int dat,
                       output int lowcnt, output int errv, output int rdv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_ch = 2'(ch);
    cmd_reg = 2'(rg); cmd_wdata = 8'(dat);
    while (!ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    errv = int'(err); rdv = int'(rsp_rdata); lowcnt = 0;
    while (!ready && lowcnt < 1000) begin
      lowcnt++;
      @(negedge clk);
    end
  endtask

  task automatic do_cmd(input int op, input int ch, input int rg, input int dat);
    int elow, eerr, erd, low, ev, rd;
    model(op, ch, rg, dat, int'(wp_n), elow, eerr, erd);
    issue(op, ch, rg, dat, low, ev, rd);
    if (eerr != 0) begin
      check("R11 err", ev, 1);
      check("R11 err width", int'(err), 0);
    end else begin
      check({tag_of(op), " err"}, ev, 0);
    end
    check({tag_of(op), " ready-low"}, low, elow);
    check({tag_of(op), " rdata"}, rd, erd);
    check_wipers({tag_of(op), " wiper"});
  endtask

  task automatic reset_and_recall(input bit first);
    @(negedge clk);
    rst_n = 1'b0;
    exp_rd = 0;
    repeat (2) @(negedge clk);
    check("R1 ready", int'(ready), 0);
    check("R1 err", int'(err), 0);
    check("R1 rdata", int'(rsp_rdata), 0);
    check("R1 wiper", int'(wiper_out), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++)
        check(first ? "R2 recall" : "R3 persist", int'(wiper_out[c*8 +: 8]),
              (c < k) ? exp_nv[c*4] : 0);
      check("R2 ready", int'(ready), (k == 4) ? 1 : 0);
    end
    for (int c = 0; c < 4; c++) exp_w[c] = exp_nv[c*4];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int low, ev, rd, held_exp;
    void'($urandom(32'h5eed_0a17));
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) exp_nv[c*4 + r] = factory(c, r);

    reset_and_recall(1'b1);

    // R3 factory contents, read back through R6
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) do_cmd(2, c, r, 0);

    // R10 saturation at both ends
    do_cmd(1, 0, 0, 254);
    do_cmd(6, 0, 0, 0);
    do_cmd(6, 0, 0, 0);
    do_cmd(1, 2, 0, 1);
    do_cmd(7, 2, 0, 0);
    do_cmd(7, 2, 0, 0);
    do_cmd(0, 2, 0, 0);

    // R7 R8 R9 transfers
    do_cmd(3, 1, 2, 8'h5A);
    do_cmd(4, 0, 3, 0);
    do_cmd(5, 3, 3, 0);
    do_cmd(5, 1, 2, 0);
    do_cmd(2, 0, 3, 0);

    // R11 write protect
    wp_n = 1'b0;
    do_cmd(3, 2, 1, 8'hC3);
    do_cmd(4, 3, 0, 0);
    do_cmd(1, 3, 0, 8'h77);
    do_cmd(2, 2, 1, 0);
    do_cmd(2, 3, 0, 0);
    wp_n = 1'b1;

    // R12 command held through a busy window
    @(negedge clk);
    model(3, 1, 0, 8'h21, 1, low, ev, rd);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_ch = 2'd1; cmd_reg = 2'd0; cmd_wdata = 8'h21;
    while (!ready) @(negedge clk);
    @(negedge clk);
    cmd_op = 3'd6; cmd_ch = 2'd1;
    held_exp = (exp_w[1] < 255) ? exp_w[1] + 1 : 255;
    exp_w[1] = held_exp;
    while (!ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R12 taken", int'(ready), 0);
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R12 once", int'(wiper_out[15:8]), held_exp);

    // Random mix, R4 through R11
    for (int i = 0; i < 400; i++) begin
      wp_n = (($urandom % 4) != 0);
      do_cmd(int'($urandom % 8), int'($urandom % 4), int'($urandom % 4),
             int'($urandom % 256));
    end
    wp_n = 1'b1;

    // R3 contents survive a second reset, and the recall uses them
    reset_and_recall(1'b0);
    do_cmd(2, 1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule